// File: doc/BRIEF.md
# Flag Offset Register Programmer

This block fills the two threshold registers of a FIFO's partial-level flags: an almost-empty offset (X) and an almost-full offset (Y). The method of filling them is picked while reset is held. Two dual-purpose pins and a mode pin are sampled during reset, and their last value before reset is released decides the method. The block can apply a fixed preset value. It can also capture one word from the write-side data bus, or shift a bit stream in through a serial-enable pin and a serial-data pin.

In serial mode X and Y form one chain of 2×OFS_W bits. The first bit shifted lands in the top bit of Y and the last bit lands in the bottom bit of X. A completion flag rises once the registers hold their final value. After that flag rises, further load attempts are ignored until the next reset. Everything runs on the write-side clock. The reset is synchronous and active high.

Top module: `flag_offset_programmer`

## Requirements
- R1: While `rst` is high, and after its release until a load completes, `ofs_done` is 0. In serial and parallel mode `ofs_x` and `ofs_y` read 0 during that time.
- R2: With `cfg_mode`=1, the pins {`sel_hi_sen_n`,`sel_lo_sdata`} sampled at reset pick a preset: 00 gives 64, 01 gives 16 and 10 gives 8. Both `ofs_x` and `ofs_y` take that value, and `ofs_done` is 1 from the first clock edge after `rst` falls.
- R3: With `cfg_mode`=1 and the pins at 11, the first edge with `wr_en`=1 after reset loads the parallel value. `ofs_x` takes `wr_data[DATA_W/2-1:0]`, `ofs_y` takes `wr_data[DATA_W-1:DATA_W/2]` (both zero-extended), and `ofs_done` becomes 1.
- R4: In parallel mode, writes after the first one change neither offset.
- R5: With `cfg_mode`=0, each clock edge with `sel_hi_sen_n`=0 shifts `sel_lo_sdata` into the {Y,X} chain at the LSB of X. The first bit shifted ends in Y's MSB and the last bit ends in X's LSB. During shifting, `ofs_x`/`ofs_y` show the chain contents.
- R6: In serial mode, `ofs_done` rises after exactly 2×OFS_W enabled edges. Edges with `sel_hi_sen_n`=1 do not shift.
- R7: Once `ofs_done` is 1, shift enables are ignored and the done flag holds until the next reset.
- R8: The load method and preset are captured only while `rst` is high. Pin changes after release do not alter them.
- R9: The serial pins have no effect in preset or parallel mode. `wr_en` has no effect in preset or serial mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-side clock |
| rst | input | 1 | Synchronous active-high master reset; method sampled while high |
| cfg_mode | input | 1 | 1: preset/parallel selection via pins, 0: serial load |
| sel_hi_sen_n | input | 1 | Select bit 1 during reset; active-low serial enable afterwards |
| sel_lo_sdata | input | 1 | Select bit 0 during reset; serial data afterwards |
| wr_en | input | 1 | Write-side enable for the parallel load |
| wr_data | input | DATA_W | Write-side data word |
| ofs_x | output | OFS_W | Almost-empty offset |
| ofs_y | output | OFS_W | Almost-full offset |
| ofs_done | output | 1 | Offsets are final |

## Verification
The hardest situation to reach is the exact boundary of the serial chain. The done flag must stay low after 2×OFS_W−1 shifts and rise on the next one, while idle edges in between must not count. The stimulus shifts a known 40-bit pattern bit by bit and inserts a gap of disabled edges in the middle. It checks the partial chain halfway, then the flag on each side of the last bit. Further enabled edges follow to confirm that the final value is frozen.

// File: rtl/fop_pkg.sv
package fop_pkg;

    typedef enum logic [1:0] {
        LD_SERIAL   = 2'd0,
        LD_PRESET   = 2'd1,
        LD_PARALLEL = 2'd2
    } load_method_e;

    typedef struct packed {
        load_method_e method;
        logic [1:0]   preset_sel;
    } load_cfg_t;

    // Select-pin decode: mode low -> serial; mode high -> 11 parallel, else preset
    function automatic load_cfg_t decode_cfg(input logic mode_hi, input logic [1:0] sel);
        load_cfg_t c;
        c.preset_sel = sel;
        if (!mode_hi)          c.method = LD_SERIAL;
        else if (sel == 2'b11) c.method = LD_PARALLEL;
        else                   c.method = LD_PRESET;
        return c;
    endfunction

    function automatic logic [7:0] preset_amount(input logic [1:0] sel);
        case (sel)
            2'b00:   return 8'd64;
            2'b01:   return 8'd16;
            2'b10:   return 8'd8;
            default: return 8'd0;
        endcase
    endfunction

endpackage

// File: rtl/fop_mode_latch.sv
module fop_mode_latch
    import fop_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       mode_i,
    input  logic [1:0] sel_i,
    output load_cfg_t  cfg_o
);

    always_ff @(posedge clk) begin
        if (rst) cfg_o <= decode_cfg(mode_i, sel_i);
    end

    AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(cfg_o)) else $error("cfg changed outside reset"); // R8

endmodule

// File: rtl/fop_serial_chain.sv
module fop_serial_chain #(
    parameter int CHAIN_W = 40
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               shift_en,
    input  logic               shift_bit,
    output logic [CHAIN_W-1:0] chain_q,
    output logic               full
);

    localparam int CNT_W = $clog2(CHAIN_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CHAIN_W - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
            cnt_q   <= '0;
            full    <= 1'b0;
        end else if (shift_en && !full) begin
            chain_q <= {chain_q[CHAIN_W-2:0], shift_bit};
            cnt_q   <= cnt_q + 1'b1;
            if (cnt_q == LAST) full <= 1'b1;
        end
    end

    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(CHAIN_W)) else $error("shift count overran"); // R6
    AST_FULL_NEEDS_SHIFT: assert property (@(posedge clk) disable iff (rst)
        $rose(full) |-> $past(shift_en)) else $error("full without shift"); // R6
    AST_NO_SHIFT_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
        full |=> $stable(chain_q) && full) else $error("chain moved after full"); // R7

endmodule

// File: rtl/fop_parallel_load.sv
module fop_parallel_load #(
    parameter int OFS_W  = 20,
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic [DATA_W-1:0] word,
    output logic [OFS_W-1:0]  x_q,
    output logic [OFS_W-1:0]  y_q,
    output logic              loaded
);

    localparam int HALF_W = DATA_W / 2;

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q    <= '0;
            y_q    <= '0;
            loaded <= 1'b0;
        end else if (load_en && !loaded) begin
            x_q    <= OFS_W'(word[HALF_W-1:0]);
            y_q    <= OFS_W'(word[2*HALF_W-1:HALF_W]);
            loaded <= 1'b1;
        end
    end

    AST_PAR_FROZEN: assert property (@(posedge clk) disable iff (rst)
        loaded |=> $stable(x_q) && $stable(y_q)) else $error("parallel reload"); // R4
    AST_PAR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
        $rose(loaded) |-> $past(load_en)) else $error("load without write"); // R3

endmodule

// File: rtl/flag_offset_programmer.sv
module flag_offset_programmer
    import fop_pkg::*;
#(
    parameter int OFS_W  = 20,
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_mode,
    input  logic              sel_hi_sen_n,
    input  logic              sel_lo_sdata,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [OFS_W-1:0]  ofs_x,
    output logic [OFS_W-1:0]  ofs_y,
    output logic              ofs_done
);

    localparam int CHAIN_W = 2 * OFS_W;

    load_cfg_t          cfg_q;
    logic [CHAIN_W-1:0] chain;
    logic               ser_full;
    logic [OFS_W-1:0]   par_x, par_y;
    logic               par_done;
    logic               pre_done;
    logic [OFS_W-1:0]   pre_val;

    fop_mode_latch i_mode (
        .clk    (clk),
        .rst    (rst),
        .mode_i (cfg_mode),
        .sel_i  ({sel_hi_sen_n, sel_lo_sdata}),
        .cfg_o  (cfg_q)
    );

    fop_serial_chain #(.CHAIN_W(CHAIN_W)) i_chain (
        .clk       (clk),
        .rst       (rst),
        .shift_en  ((cfg_q.method == LD_SERIAL) && !sel_hi_sen_n),
        .shift_bit (sel_lo_sdata),
        .chain_q   (chain),
        .full      (ser_full)
    );

    fop_parallel_load #(.OFS_W(OFS_W), .DATA_W(DATA_W)) i_par (
        .clk     (clk),
        .rst     (rst),
        .load_en ((cfg_q.method == LD_PARALLEL) && wr_en),
        .word    (wr_data),
        .x_q     (par_x),
        .y_q     (par_y),
        .loaded  (par_done)
    );

    // Preset completes on the first edge after reset release
    always_ff @(posedge clk) begin
        if (rst) pre_done <= 1'b0;
        else if (cfg_q.method == LD_PRESET) pre_done <= 1'b1;
    end

    assign pre_val = OFS_W'(preset_amount(cfg_q.preset_sel));

    always_comb begin
        case (cfg_q.method)
            LD_PRESET: begin
                ofs_x    = pre_val;
                ofs_y    = pre_val;
                ofs_done = pre_done;
            end
            LD_PARALLEL: begin
                ofs_x    = par_x;
                ofs_y    = par_y;
                ofs_done = par_done;
            end
            default: begin
                ofs_x    = chain[OFS_W-1:0];
                ofs_y    = chain[CHAIN_W-1:OFS_W];
                ofs_done = ser_full;
            end
        endcase
    end

    AST_DONE_LOW_IN_RESET: assert property (@(posedge clk)
        rst |=> !pre_done && !par_done && !ser_full) else $error("done set in reset"); // R1
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        ofs_done |=> ofs_done && $stable(ofs_x) && $stable(ofs_y)) else $error("done not sticky"); // R7
    AST_PRESET_DONE: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.method == LD_PRESET) |=> ofs_done) else $error("preset not done"); // R2

endmodule

// File: tb/test_flag_offset_programmer.sv
module test_flag_offset_programmer;

    localparam int OFS_W   = 20;
    localparam int DATA_W  = 36;
    localparam int CHAIN_W = 2 * OFS_W;
    localparam int VEC_W   = 4 + DATA_W + 2 * OFS_W;
    localparam int NVEC    = 7;

    // {mode, sel[1:0], do_write, data, exp_x, exp_y}
    localparam logic [VEC_W-1:0] VECS [NVEC] = '{
        {1'b1, 2'b00, 1'b0, 36'h0,                20'd64,     20'd64},     // R2
        {1'b1, 2'b01, 1'b0, 36'h0,                20'd16,     20'd16},     // R2
        {1'b1, 2'b10, 1'b0, 36'h0,                20'd8,      20'd8},      // R2
        {1'b1, 2'b11, 1'b1, 18'h3FFFF, 18'h00000, 20'h00000,  20'h3FFFF},  // R3
        {1'b1, 2'b11, 1'b1, 18'h20001, 18'h18003, 20'h18003,  20'h20001},  // R3
        {1'b1, 2'b11, 1'b1, 18'h00AAA, 18'h35555, 20'h35555,  20'h00AAA},  // R3
        {1'b1, 2'b01, 1'b1, 36'hFFFFFFFFF,        20'd16,     20'd16}      // R9
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_mode = 1'b1;
    logic              sel_hi_sen_n = 1'b1;
    logic              sel_lo_sdata = 1'b0;
    logic              wr_en = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [OFS_W-1:0]  ofs_x, ofs_y;
    logic              ofs_done;

    int checks = 0;
    int errors = 0;
    bit ended  = 1'b0;

    always #10 clk = ~clk;

    flag_offset_programmer #(.OFS_W(OFS_W), .DATA_W(DATA_W)) i_flag_offset_programmer (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .sel_hi_sen_n(sel_hi_sen_n),
        .sel_lo_sdata(sel_lo_sdata), .wr_en(wr_en), .wr_data(wr_data),
        .ofs_x(ofs_x), .ofs_y(ofs_y), .ofs_done(ofs_done)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic do_reset(input logic m, input logic [1:0] s);
        @(negedge clk);
        rst = 1'b1; cfg_mode = m; {sel_hi_sen_n, sel_lo_sdata} = s; wr_en = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        sel_hi_sen_n = 1'b1;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic write_word(input logic [DATA_W-1:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic push(input logic b);
        sel_hi_sen_n = 1'b0; sel_lo_sdata = b;
        @(negedge clk);
        sel_hi_sen_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        logic [CHAIN_W-1:0] pat;
        pat = 40'hA53C9F0E71;

        // R1: reset state in parallel mode
        do_reset(1'b1, 2'b11);
        check("R1 done after release", 64'(ofs_done), 64'd0);
        check("R1 x zero", 64'(ofs_x), 64'd0);
        check("R1 y zero", 64'(ofs_y), 64'd0);

        // table walk: presets and parallel loads
        for (int i = 0; i < NVEC; i++) begin
            logic [VEC_W-1:0] v;
            v = VECS[i];
            do_reset(v[VEC_W-1], v[VEC_W-2 -: 2]);
            if (v[VEC_W-4]) write_word(v[2*OFS_W +: DATA_W]);
            else idle();
            idle();
            check("R2/R3/R9 table x", 64'(ofs_x), 64'(v[OFS_W +: OFS_W]));
            check("R2/R3/R9 table y", 64'(ofs_y), 64'(v[0 +: OFS_W]));
            check("R2/R3/R9 table done", 64'(ofs_done), 64'd1);
        end

        // R2: done exactly on first edge after release
        do_reset(1'b1, 2'b10);
        check("R2 done before first edge", 64'(ofs_done), 64'd0);
        idle();
        check("R2 done after first edge", 64'(ofs_done), 64'd1);
        check("R2 preset 8", 64'(ofs_x), 64'd8);

        // R8: pins changed after release do not alter method
        cfg_mode = 1'b0; sel_lo_sdata = 1'b1;
        repeat (3) idle();
        check("R8 preset kept", 64'(ofs_y), 64'd8);
        check("R8 done kept", 64'(ofs_done), 64'd1);

        // R9 and R4: parallel mode ignores serial pins; second write ignored
        do_reset(1'b1, 2'b11);
        for (int k = 0; k < 4; k++) push(k[0]);
        check("R9 serial pins ignored x", 64'(ofs_x), 64'd0);
        check("R9 serial pins ignored done", 64'(ofs_done), 64'd0);
        write_word({18'h12345, 18'h0ABCD});
        write_word({18'h3FFFF, 18'h3FFFF});
        idle();
        check("R4 first x kept", 64'(ofs_x), 64'h0ABCD);
        check("R4 first y kept", 64'(ofs_y), 64'h12345);

        // R5/R6/R7: serial load
        do_reset(1'b0, 2'b10);
        write_word('1);
        check("R9 wr ignored in serial", 64'({ofs_y, ofs_x}), 64'd0);
        check("R9 wr no done", 64'(ofs_done), 64'd0);
        for (int i = CHAIN_W - 1; i >= 1; i--) begin
            push(pat[i]);
            if (i == 20) begin
                check("R5 half chain x", 64'(ofs_x), 64'(pat[CHAIN_W-1 -: OFS_W]));
                check("R5 half chain y", 64'(ofs_y), 64'd0);
                sel_lo_sdata = 1'b1;
                repeat (3) idle();
                check("R6 idle edges no shift", 64'(ofs_x), 64'(pat[CHAIN_W-1 -: OFS_W]));
            end
        end
        check("R6 not done at 2W-1", 64'(ofs_done), 64'd0);
        push(pat[0]);
        check("R6 done at 2W", 64'(ofs_done), 64'd1);
        check("R5 final y", 64'(ofs_y), 64'(pat[CHAIN_W-1 -: OFS_W]));
        check("R5 final x", 64'(ofs_x), 64'(pat[OFS_W-1:0]));
        for (int k = 0; k < 5; k++) push(~pat[k]);
        check("R7 chain frozen", 64'({ofs_y, ofs_x}), 64'(pat));
        check("R7 done held", 64'(ofs_done), 64'd1);

        // R1: new reset clears serial result
        do_reset(1'b0, 2'b10);
        check("R1 serial cleared", 64'({ofs_y, ofs_x}), 64'd0);
        check("R1 serial done cleared", 64'(ofs_done), 64'd0);

        finish_run();
    end

endmodule